// File: doc/BRIEF.md
# Dispatch Skid Buffer Controller

This block controls dispatch for one thread. It sits between the rename stage and the instruction and load/store queues. Each cycle rename can offer a packed group of up to `GRP_W` instructions. Each lane carries a flag saying it was already squashed and a flag saying it is a memory (load or store) operation. The block hands up to `DISP_W` of them to the queues per cycle and reports how many it consumed. It also reports how many of those went to the load/store side and how many were inserted into the instruction queue.

When a stall arises, or the queues fill part way through a group, the instructions left over are parked in a skid FIFO and rename is told to block. After the stall clears, the block feeds the queues from the skid FIFO, oldest entry first. Rename is released only once the FIFO has drained. A squash from commit overrides everything else: it empties the FIFO and discards the live group.

All outputs are registered. The result for the inputs seen at one rising edge is visible after that edge.

Top module: `dispatch_skid_ctrl`

## Requirements
- R1: While reset is asserted and right after it is released, `state_o` is 0 (idle), every count output is 0, and `blk_o` and `unblk_o` are 0.
- R2: The skid FIFO holds `3*LAT*GRP_W + ISSUE_W` entries, which is 16 with the default parameters. A full FIFO holding 16 parked instructions drains at `DISP_W` per cycle, oldest first, and nothing is lost.
- R3: `cmt_squash_i` has priority over every other input. In that cycle the FIFO and the live group are discarded and all counts are 0. The state becomes squashing (4). `unblk_o` is 1 if the previous state was blocked (2) or unblocking (3).
- R4: A stall is any of the following:
  - the commit stall flag is set; `cmt_stall_set_i` sets it and `cmt_stall_clr_i` clears it, and clear wins when both are high;
  - `iq_free_i` is 0;
  - `lsq_free_i` is 0;
  - `lsq_stall_i` is high.
  On a stall the whole live group is parked, the counts are 0 and the state becomes blocked (2). `blk_o` pulses only if the previous state was neither blocked nor unblocking.
- R5: In a blocked cycle with no stall, the state passes through unblocking, and instructions come from the FIFO instead of the live group. Any live group in that cycle is appended behind the remaining FIFO entries. If the FIFO was not emptied by that cycle's dispatch, the state returns to blocked (2). If the FIFO was emptied but new entries were appended, the state is unblocking (3).
- R6: When the FIFO is empty after a cycle's dispatch and append, `unblk_o` pulses and the state becomes running (1).
- R7: A lane flagged squashed is consumed without an instruction-queue insertion. It adds 1 to `disp_n_o`, and 1 to `lsq_n_o` as well if it is a memory operation. A lane that is inserted adds 1 to `iq_n_o` and to `disp_n_o`, and 1 to `lsq_n_o` if it is a memory operation.
- R8: Dispatch stops early when any of these happens:
  - `DISP_W` lanes have been taken;
  - `iq_free_i` runs out within the group;
  - `lsq_free_i` runs out on a memory lane.
  If live lanes are then left over, they are parked in order, `blk_o` pulses, `unblk_o` is forced to 0 and the state becomes blocked (2).
- R9: From squashing, the next cycle that has neither a squash nor a stall is treated as running, and that cycle's group is dispatched.
- R10: From idle (0), the first cycle that consumes at least one instruction moves the state to running (1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| grp_n_i | input | $clog2(GRP_W+1) | Number of live lanes in this cycle's group, packed from lane 0, at most GRP_W |
| grp_sq_i | input | GRP_W | Per-lane already-squashed flag |
| grp_mem_i | input | GRP_W | Per-lane memory-operation flag |
| iq_free_i | input | FREE_W | Free instruction-queue slots this cycle |
| lsq_free_i | input | FREE_W | Free load/store-queue slots this cycle |
| lsq_stall_i | input | 1 | Load/store side requests a stall |
| cmt_stall_set_i | input | 1 | Commit raises its stall flag |
| cmt_stall_clr_i | input | 1 | Commit drops its stall flag |
| cmt_squash_i | input | 1 | Commit squashes this thread |
| blk_o | output | 1 | Pulse telling rename to block |
| unblk_o | output | 1 | Pulse telling rename it may resume |
| disp_n_o | output | $clog2(DISP_W+1) | Instructions consumed in the last cycle |
| lsq_n_o | output | $clog2(DISP_W+1) | Consumed instructions that were memory operations |
| iq_n_o | output | $clog2(DISP_W+1) | Instructions inserted into the instruction queue |
| state_o | output | 3 | 0 idle, 1 running, 2 blocked, 3 unblocking, 4 squashing |

## Verification
Every output is due exactly one rising edge after the inputs that cause it. The bench applies a group on a falling edge, updates its own model of the FIFO and state machine for that cycle, and compares all six outputs on the following falling edge. It never samples at the edge itself. Multi-cycle effects are checked one cycle at a time along the same half-period offset. These effects are the drain of a full FIFO, the unblocking cycle that appends new lanes, and the flushed FIFO showing no dispatch after a squash.

// File: rtl/dsp_pkg.sv
`timescale 1ns/1ps
package dsp_pkg;
  typedef struct packed {
    logic sq;
    logic mem;
  } dent_t;

  typedef enum logic [2:0] {
    DS_IDLE = 3'd0,
    DS_RUN  = 3'd1,
    DS_BLK  = 3'd2,
    DS_UNB  = 3'd3,
    DS_SQ   = 3'd4
  } dstate_e;
endpackage

// File: rtl/dsp_skid.sv
`timescale 1ns/1ps
module dsp_skid
  import dsp_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int GRP_W  = 4,
  parameter int DISP_W = 3,
  localparam int AW  = $clog2(DEPTH),
  localparam int CW  = $clog2(DEPTH + 1),
  localparam int LGW = $clog2(GRP_W + 1),
  localparam int UW  = $clog2(DISP_W + 1)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           flush_i,
  input  logic [UW-1:0]  pop_n_i,
  input  logic [LGW-1:0] push_lo_i,
  input  logic [LGW-1:0] push_hi_i,
  input  dent_t          push_d_i [GRP_W],
  output dent_t          head_o   [DISP_W],
  output logic [CW-1:0]  cnt_o
);
  logic [AW-1:0] rd_q, wr_q;
  logic [CW-1:0] cnt_q, keep, room, req, acc;
  dent_t         mem_q [2**AW];

  assign keep = cnt_q - CW'(pop_n_i);
  assign room = CW'(DEPTH) - keep;
  assign req  = (push_hi_i > push_lo_i) ? CW'(push_hi_i - push_lo_i) : '0;
  assign acc  = (req > room) ? room : req;

  always_ff @(posedge clk_i) begin
    for (int i = 0; i < GRP_W; i++) begin
      if (!flush_i && LGW'(i) >= push_lo_i && LGW'(i) < push_hi_i &&
          CW'(i - int'(push_lo_i)) < acc)
        mem_q[wr_q + AW'(i - int'(push_lo_i))] <= push_d_i[i];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else if (flush_i) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      rd_q  <= rd_q + AW'(pop_n_i);
      wr_q  <= wr_q + AW'(acc);
      cnt_q <= keep + acc;
    end
  end

  for (genvar g = 0; g < DISP_W; g++) begin : g_head
    assign head_o[g] = mem_q[rd_q + AW'(g)];
  end

  assign cnt_o = cnt_q;

  // R2
  skid_ovf_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flush_i |-> (req <= room));

  // R2
  skid_undf_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flush_i |-> (CW'(pop_n_i) <= cnt_q));
endmodule

// File: rtl/dsp_pick.sv
`timescale 1ns/1ps
module dsp_pick
  import dsp_pkg::*;
#(
  parameter int DISP_W = 3,
  parameter int FREE_W = 4,
  parameter int AVW    = 5,
  localparam int UW = $clog2(DISP_W + 1)
) (
  input  dent_t             ent_i [DISP_W],
  input  logic [AVW-1:0]    avail_i,
  input  logic [FREE_W-1:0] iq_free_i,
  input  logic [FREE_W-1:0] lsq_free_i,
  output logic [UW-1:0]     used_o,
  output logic [UW-1:0]     lsq_o,
  output logic [UW-1:0]     iq_o
);
  logic [FREE_W-1:0] iq_left, lq_left;
  logic              halt;

  // in-order walk; a squashed lane never needs a slot
  always_comb begin
    iq_left = iq_free_i;
    lq_left = lsq_free_i;
    halt    = 1'b0;
    used_o  = '0;
    lsq_o   = '0;
    iq_o    = '0;
    for (int i = 0; i < DISP_W; i++) begin
      if (!halt && AVW'(i) < avail_i) begin
        if (ent_i[i].sq) begin
          used_o = used_o + UW'(1);
          lsq_o  = lsq_o + UW'(ent_i[i].mem);
        end else if (iq_left == '0 || (ent_i[i].mem && lq_left == '0)) begin
          halt = 1'b1;
        end else begin
          used_o  = used_o + UW'(1);
          iq_o    = iq_o + UW'(1);
          lsq_o   = lsq_o + UW'(ent_i[i].mem);
          iq_left = iq_left - FREE_W'(1);
          lq_left = lq_left - FREE_W'(ent_i[i].mem);
        end
      end
    end
  end
endmodule

// File: rtl/dispatch_skid_ctrl.sv
`timescale 1ns/1ps
module dispatch_skid_ctrl
  import dsp_pkg::*;
#(
  parameter int GRP_W   = 4,
  parameter int DISP_W  = 3,
  parameter int LAT     = 1,
  parameter int ISSUE_W = 4,
  parameter int FREE_W  = 4,
  localparam int DEPTH = 3 * LAT * GRP_W + ISSUE_W,
  localparam int CW    = $clog2(DEPTH + 1),
  localparam int LGW   = $clog2(GRP_W + 1),
  localparam int UW    = $clog2(DISP_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [LGW-1:0]    grp_n_i,
  input  logic [GRP_W-1:0]  grp_sq_i,
  input  logic [GRP_W-1:0]  grp_mem_i,
  input  logic [FREE_W-1:0] iq_free_i,
  input  logic [FREE_W-1:0] lsq_free_i,
  input  logic              lsq_stall_i,
  input  logic              cmt_stall_set_i,
  input  logic              cmt_stall_clr_i,
  input  logic              cmt_squash_i,
  output logic              blk_o,
  output logic              unblk_o,
  output logic [UW-1:0]     disp_n_o,
  output logic [UW-1:0]     lsq_n_o,
  output logic [UW-1:0]     iq_n_o,
  output logic [2:0]        state_o
);
  dstate_e        state_q, s_mid, s_n;
  logic           st_q, st_n, stall, rel_unblk, from_skid;
  logic           blk_q, unblk_q, blk_d, unblk_d, flush;
  logic [UW-1:0]  nd_q, nl_q, ni_q, nd, nl, ni;
  logic [UW-1:0]  used, p_lsq, p_iq, pop_n;
  logic [LGW-1:0] push_lo, push_hi;
  logic [CW-1:0]  skid_cnt, avail, grp_x;
  dent_t          din  [GRP_W];
  dent_t          head [DISP_W];
  dent_t          src  [DISP_W];

  for (genvar g = 0; g < GRP_W; g++) begin : g_din
    assign din[g] = dent_t'({grp_sq_i[g], grp_mem_i[g]});
  end

  assign grp_x = CW'(grp_n_i);

  // commit stall flag: clear wins over set
  assign st_n  = cmt_stall_clr_i ? 1'b0 : (cmt_stall_set_i ? 1'b1 : st_q);
  assign stall = st_n || (iq_free_i == '0) || (lsq_free_i == '0) || lsq_stall_i;

  // state seen by dispatch when no squash or stall is present
  always_comb begin
    s_mid     = state_q;
    rel_unblk = 1'b0;
    if (state_q == DS_BLK) begin
      s_mid = DS_UNB;
      if (skid_cnt == '0) begin
        s_mid     = DS_RUN;
        rel_unblk = 1'b1;
      end
    end else if (state_q == DS_SQ) begin
      s_mid = DS_RUN;
    end
  end

  assign from_skid = (s_mid == DS_UNB);
  assign avail     = from_skid ? skid_cnt : grp_x;

  for (genvar g = 0; g < DISP_W; g++) begin : g_src
    if (g < GRP_W) begin : g_in
      assign src[g] = from_skid ? head[g] : din[g];
    end else begin : g_sk
      assign src[g] = from_skid ? head[g] : dent_t'('0);
    end
  end

  dsp_pick #(
    .DISP_W(DISP_W), .FREE_W(FREE_W), .AVW(CW)
  ) u_pick (
    .ent_i     (src),
    .avail_i   (avail),
    .iq_free_i (iq_free_i),
    .lsq_free_i(lsq_free_i),
    .used_o    (used),
    .lsq_o     (p_lsq),
    .iq_o      (p_iq)
  );

  always_comb begin
    blk_d   = 1'b0;
    unblk_d = 1'b0;
    flush   = 1'b0;
    pop_n   = '0;
    push_lo = '0;
    push_hi = '0;
    nd      = '0;
    nl      = '0;
    ni      = '0;
    s_n     = state_q;
    if (cmt_squash_i) begin
      flush   = 1'b1;
      unblk_d = (state_q == DS_BLK) || (state_q == DS_UNB);
      s_n     = DS_SQ;
    end else if (stall) begin
      blk_d   = !((state_q == DS_BLK) || (state_q == DS_UNB));
      push_hi = grp_n_i;
      s_n     = DS_BLK;
    end else begin
      s_n     = s_mid;
      unblk_d = rel_unblk;
      nd      = used;
      nl      = p_lsq;
      ni      = p_iq;
      if (s_mid == DS_UNB) begin
        pop_n   = used;
        push_hi = grp_n_i;
        if (skid_cnt > CW'(used)) begin
          s_n     = DS_BLK;
          unblk_d = 1'b0;
        end else if (grp_n_i == '0) begin
          s_n     = DS_RUN;
          unblk_d = 1'b1;
        end
      end else if (grp_x > CW'(used)) begin
        blk_d   = 1'b1;
        unblk_d = 1'b0;
        push_lo = LGW'(used);
        push_hi = grp_n_i;
        s_n     = DS_BLK;
      end else if (s_mid == DS_IDLE && used != '0) begin
        s_n = DS_RUN;
      end
    end
  end

  dsp_skid #(
    .DEPTH(DEPTH), .GRP_W(GRP_W), .DISP_W(DISP_W)
  ) u_skid (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .flush_i  (flush),
    .pop_n_i  (pop_n),
    .push_lo_i(push_lo),
    .push_hi_i(push_hi),
    .push_d_i (din),
    .head_o   (head),
    .cnt_o    (skid_cnt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= DS_IDLE;
      st_q    <= 1'b0;
      blk_q   <= 1'b0;
      unblk_q <= 1'b0;
      nd_q    <= '0;
      nl_q    <= '0;
      ni_q    <= '0;
    end else begin
      state_q <= s_n;
      st_q    <= st_n;
      blk_q   <= blk_d;
      unblk_q <= unblk_d;
      nd_q    <= nd;
      nl_q    <= nl;
      ni_q    <= ni;
    end
  end

  assign blk_o    = blk_q;
  assign unblk_o  = unblk_q;
  assign disp_n_o = nd_q;
  assign lsq_n_o  = nl_q;
  assign iq_n_o   = ni_q;
  assign state_o  = state_q;

  // R4
  blk_once_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blk_q |-> ($past(state_q) != DS_BLK && $past(state_q) != DS_UNB));

  // R3
  sq_flush_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmt_squash_i |=> (state_q == DS_SQ && skid_cnt == '0 && nd_q == '0));

  // R5
  unb_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == DS_UNB) |-> (skid_cnt != '0));

  // R6
  unblk_state_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unblk_q |-> (state_q == DS_RUN || state_q == DS_SQ));

  // R8
  blk_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blk_q |-> (!unblk_q && state_q == DS_BLK));
endmodule

// File: tb/dispatch_skid_ctrl_test.sv
`timescale 1ns/1ps
module dispatch_skid_ctrl_test;
  localparam int GRP_W = 4, DISP_W = 3, LAT = 1, ISSUE_W = 4, FREE_W = 4;
  localparam int DEPTH = 3 * LAT * GRP_W + ISSUE_W;
  localparam int LGW = $clog2(GRP_W + 1), UW = $clog2(DISP_W + 1);

  logic clk = 0, rst_ni = 0;
  logic [LGW-1:0] grp_n = 0;
  logic [GRP_W-1:0] gsq = 0, gmem = 0;
  logic [FREE_W-1:0] iqf = 0, lqf = 0;
  logic lst = 0, sset = 0, sclr = 0, sqs = 0;
  logic blk_o, unblk_o;
  logic [UW-1:0] disp_n_o, lsq_n_o, iq_n_o;
  logic [2:0] state_o;

  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  dispatch_skid_ctrl #(.GRP_W(GRP_W), .DISP_W(DISP_W), .LAT(LAT), .ISSUE_W(ISSUE_W),
                       .FREE_W(FREE_W)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .grp_n_i(grp_n), .grp_sq_i(gsq), .grp_mem_i(gmem),
    .iq_free_i(iqf), .lsq_free_i(lqf), .lsq_stall_i(lst), .cmt_stall_set_i(sset),
    .cmt_stall_clr_i(sclr), .cmt_squash_i(sqs), .blk_o(blk_o), .unblk_o(unblk_o),
    .disp_n_o(disp_n_o), .lsq_n_o(lsq_n_o), .iq_n_o(iq_n_o), .state_o(state_o));

  // reference model
  int m_s = 0;
  bit m_st = 0;
  bit [1:0] mq[$];
  bit e_blk, e_unb;
  int e_d, e_l, e_i;
  string m_tag;

  task automatic m_pick(input bit fs, output int used, output int pl, output int pi);
    int iql, lql, avail;
    bit halt;
    bit [1:0] ent;
    iql = iqf; lql = lqf; halt = 0; used = 0; pl = 0; pi = 0;
    avail = fs ? mq.size() : int'(grp_n);
    for (int i = 0; i < DISP_W; i++) begin
      if (!halt && i < avail) begin
        ent = fs ? mq[i] : {gsq[i], gmem[i]};
        if (ent[1]) begin used++; pl += ent[0]; end
        else if (iql == 0 || (ent[0] && lql == 0)) halt = 1;
        else begin used++; pi++; pl += ent[0]; iql--; lql -= ent[0]; end
      end
    end
  endtask

  task automatic model_step();
    bit nst, stall;
    int used, pl, pi, cnt0;
    nst = sclr ? 1'b0 : (sset ? 1'b1 : m_st);
    stall = nst || iqf == 0 || lqf == 0 || lst;
    e_blk = 0; e_unb = 0; e_d = 0; e_l = 0; e_i = 0; m_tag = "R7";
    if (sqs) begin
      e_unb = (m_s == 2 || m_s == 3);
      mq.delete();
      m_s = 4; m_tag = "R3";
    end else if (stall) begin
      e_blk = !(m_s == 2 || m_s == 3);
      for (int i = 0; i < int'(grp_n); i++) mq.push_back({gsq[i], gmem[i]});
      m_s = 2; m_tag = "R4";
    end else begin
      if (m_s == 2) begin
        m_s = 3;
        if (mq.size() == 0) begin e_unb = 1; m_s = 1; m_tag = "R6"; end
      end else if (m_s == 4) begin
        m_s = 1; m_tag = "R9";
      end
      if (m_s == 3) begin
        cnt0 = mq.size();
        m_pick(1, used, pl, pi);
        for (int i = 0; i < used; i++) void'(mq.pop_front());
        for (int i = 0; i < int'(grp_n); i++) mq.push_back({gsq[i], gmem[i]});
        m_tag = "R5";
        if (cnt0 > used) begin m_s = 2; e_unb = 0; end
        else if (grp_n == 0) begin e_unb = 1; m_s = 1; m_tag = "R6"; end
      end else begin
        m_pick(0, used, pl, pi);
        if (int'(grp_n) > used) begin
          e_blk = 1; e_unb = 0; m_s = 2; m_tag = "R8";
          for (int i = used; i < int'(grp_n); i++) mq.push_back({gsq[i], gmem[i]});
        end else if (m_s == 0 && used > 0) begin
          m_s = 1; m_tag = "R10";
        end
      end
      e_d = used; e_l = pl; e_i = pi;
    end
    m_st = nst;
  endtask

  task automatic hc(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cmp_all(input string tag);
    logic [11:0] a, e;
    a = {blk_o, unblk_o, 2'(disp_n_o), 2'(lsq_n_o), 2'(iq_n_o), state_o};
    e = {e_blk, e_unb, 2'(e_d), 2'(e_l), 2'(e_i), 3'(m_s)};
    checks++;
    if (a !== e) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, a, e);
    end
  endtask

  // called at a falling edge; returns at the next falling edge after comparing
  task automatic cyc(input int n, input logic [GRP_W-1:0] s, input logic [GRP_W-1:0] m,
                     input int iq, input int lq, input bit ls, input bit ss, input bit sc,
                     input bit q);
    string t;
    grp_n = LGW'(n); gsq = s; gmem = m; iqf = FREE_W'(iq); lqf = FREE_W'(lq);
    lst = ls; sset = ss; sclr = sc; sqs = q;
    model_step();
    t = m_tag;
    @(posedge clk);
    @(negedge clk);
    cmp_all(t);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    bit up_blk;
    int n, iq, lq;
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset values
    hc("R1 state", int'(state_o), 0);
    hc("R1 counts", int'(disp_n_o) + int'(lsq_n_o) + int'(iq_n_o), 0);
    hc("R1 handshake", int'(blk_o) + int'(unblk_o), 0);
    rst_ni = 1;
    cyc(0, 0, 0, 8, 8, 0, 0, 0, 0);
    hc("R1 idle", int'(state_o), 0);

    // R10: first dispatch leaves idle
    cyc(2, 4'b0000, 4'b0000, 8, 8, 0, 0, 0, 0);
    hc("R10 state", int'(state_o), 1);
    hc("R10 disp", int'(disp_n_o), 2);

    // R7: squashed lane dropped but counted
    cyc(3, 4'b0010, 4'b0110, 8, 8, 0, 0, 0, 0);
    hc("R7 disp", int'(disp_n_o), 3);
    hc("R7 lsq", int'(lsq_n_o), 2);
    hc("R7 iq", int'(iq_n_o), 2);

    // R8: width limit parks the rest
    cyc(4, 0, 0, 8, 8, 0, 0, 0, 0);
    hc("R8 disp", int'(disp_n_o), 3);
    hc("R8 blk", int'(blk_o), 1);
    hc("R8 state", int'(state_o), 2);
    cyc(0, 0, 0, 8, 8, 0, 0, 0, 0);
    hc("R6 unblk", int'(unblk_o), 1);
    hc("R6 disp", int'(disp_n_o), 1);
    hc("R6 state", int'(state_o), 1);

    // R2/R4: fill skid to capacity under commit stall
    cyc(4, 0, 0, 8, 8, 0, 1, 0, 0);
    hc("R4 blk first", int'(blk_o), 1);
    for (int k = 0; k < 3; k++) begin
      cyc(4, 0, 0, 8, 8, 0, 0, 0, 0);
      hc("R4 blk again", int'(blk_o), 0);
    end
    hc("R2 model fill", mq.size(), DEPTH);
    for (int k = 0; k < 5; k++) begin
      cyc(0, 0, 0, 8, 8, 0, 0, (k == 0), 0);
      hc("R2 drain", int'(disp_n_o), 3);
    end
    cyc(0, 0, 0, 8, 8, 0, 0, 0, 0);
    hc("R2 last", int'(disp_n_o), 1);
    hc("R6 release", int'(unblk_o), 1);

    // R8: IQ runs out mid group; R3 squash flushes
    cyc(3, 0, 0, 1, 8, 0, 0, 0, 0);
    hc("R8 iq part", int'(iq_n_o), 1);
    hc("R8 unblk low", int'(unblk_o), 0);
    cyc(2, 0, 0, 8, 8, 0, 0, 0, 1);
    hc("R3 unblk", int'(unblk_o), 1);
    hc("R3 state", int'(state_o), 4);
    cyc(2, 0, 0, 8, 8, 0, 0, 0, 0);
    hc("R9 state", int'(state_o), 1);
    hc("R9 disp", int'(disp_n_o), 2);
    cyc(0, 0, 0, 0, 8, 0, 0, 0, 0);
    cyc(0, 0, 0, 8, 8, 0, 0, 0, 0);
    hc("R3 flushed", int'(disp_n_o), 0);
    hc("R3 flushed unblk", int'(unblk_o), 1);

    // R3 over stall; R4 other causes
    cyc(2, 0, 0, 0, 8, 1, 0, 0, 1);
    hc("R3 priority", int'(state_o), 4);
    cyc(1, 0, 0, 8, 8, 1, 0, 0, 0);
    hc("R4 lsq stall", int'(blk_o), 1);
    cyc(0, 0, 0, 8, 0, 0, 0, 0, 0);
    hc("R4 lsq full", int'(state_o), 2);
    cyc(0, 0, 0, 8, 8, 0, 0, 0, 0);

    // R5: append while unblocking
    cyc(2, 0, 0, 8, 8, 1, 0, 0, 0);
    cyc(2, 4'b0011, 4'b0011, 8, 8, 0, 0, 0, 0);
    hc("R5 state", int'(state_o), 3);
    hc("R5 disp", int'(disp_n_o), 2);
    hc("R5 lsq", int'(lsq_n_o), 0);
    cyc(0, 0, 0, 8, 8, 0, 0, 0, 0);
    hc("R5 order lsq", int'(lsq_n_o), 2);
    hc("R6 after append", int'(unblk_o), 1);

    // constrained random
    up_blk = 0;
    for (int k = 0; k < 4000; k++) begin
      n = up_blk ? 0 : int'($urandom % (GRP_W + 1));
      if (mq.size() + n > DEPTH) n = 0;
      iq = ($urandom % 10 == 0) ? 0 : int'($urandom % 8);
      lq = ($urandom % 10 == 0) ? 0 : int'($urandom % 8);
      cyc(n, 4'($urandom % 16 & $urandom % 16 & $urandom % 16), 4'($urandom % 16),
          iq, lq, ($urandom % 20 == 0), ($urandom % 30 == 0),
          (m_st && $urandom % 6 == 0), ($urandom % 40 == 0));
      if (blk_o) up_blk = 1;
      if (unblk_o) up_blk = 0;
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule